// File: doc/BRIEF.md
# Single-Accumulator Processor Core with Interrupt Check

This block is a small stored-program processor. One 16-bit accumulator is its only data register, and one memory port serves both instruction fetches and data accesses. Each instruction passes through the same sequence of phases:

1. A fetch phase reads the word at the program counter into the instruction register and advances the counter.
2. An execute phase loads, stores or adds a directly addressed word.
3. An interrupt-check phase decides whether the next fetch comes from the program or from a fixed handler entry.

A request on `irq` is latched as pending and is serviced at the next interrupt check while interrupts are enabled. Servicing saves the program counter and masks further requests. A return instruction restores the counter and unmasks. A halt instruction stops the core.

The memory port has a fixed latency and no back-pressure. A read strobe in one cycle returns its word on `mem_rdata` in the next cycle. A write strobe completes in the cycle it is asserted. The core never waits on the memory.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word carries its opcode in bits [15:12] and a direct word address in bits [11:0]; the encodings are 0x1 load, 0x2 store, 0x5 add, 0xE return-from-interrupt and 0x0 halt.
- R2: Each instruction starts with a read of the program-counter address, with `mem_rd` high for one cycle. The returned word is taken from `mem_rdata` in the following cycle, and the program counter then advances by one, modulo 4096.
- R3: Load (0x1) drives a read of its address in the cycle after the fetch data is captured, and replaces the accumulator with the word returned one cycle later.
- R4: Store (0x2) drives `mem_wr` for one cycle with the operand address and the accumulator value on `mem_wdata`.
- R5: Add (0x5) reads its address like a load and leaves the sum modulo 2^16 in the accumulator.
- R6: In the interrupt-check cycle after every executed instruction, a pending request with interrupts enabled saves the program counter, masks interrupts and makes the next fetch come from HANDLER_ADDR (default 0xF00). Otherwise the next fetch uses the program counter.
- R7: A one-cycle pulse on `irq` stays pending until it is serviced. While interrupts are masked it is held and is serviced at the first check after the return.
- R8: Return-from-interrupt (0xE) reloads the program counter from the saved value and re-enables interrupts before the check of the same instruction.
- R9: Halt (0x0) raises `halted` two cycles after its fetch read. From then on `halted` stays high and no memory access is made.
- R10: Any other opcode makes no memory access and changes nothing but the program counter.
- R11: Synchronous reset clears the program counter and accumulator and enables interrupts. The first cycle after reset is a fetch read of address 0 with `halted` low.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address of the current access |
| mem_rd | output | 1 | Read strobe; data valid on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| irq | input | 1 | Interrupt request, latched while high |
| halted | output | 1 | Core has executed a halt |

## Verification
The bench compares every memory access, in order, against an instruction-level model. An interrupt is raised by the same store that triggers it, so it lands at the check that directly follows that store. A design that sampled the request one cycle late, or missed the latched pulse, would fetch the instruction after the store instead of 0xF00.

A second request is raised from inside the handler. A core that did not mask requests would re-enter the handler at once. A core that dropped the masked request would never run the handler a second time, and the handler counter would read 1 instead of 2.

Directed code adds 0xFFFF and 2, and a design without 16-bit wrap would store the wrong value. The same code also runs an unused opcode whose address field is non-zero, and a core that decoded it as an access would show an extra bus operation. After a halt, any further access is reported.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_HALT  = 4'h0;
  localparam int OPC_LOAD  = 4'h1;
  localparam int OPC_STORE = 4'h2;
  localparam int OPC_ADD   = 4'h5;
  localparam int OPC_RETI  = 4'hE;

  typedef enum logic [2:0] {
    PH_FREQ = 3'd0,   // fetch read request
    PH_FCAP = 3'd1,   // fetch data capture
    PH_EXEC = 3'd2,   // execute / operand request
    PH_DCAP = 3'd3,   // operand data capture
    PH_ICHK = 3'd4,   // interrupt check
    PH_HALT = 3'd5
  } phase_t;

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   fetch_halt_i,
  input  logic   exec_reads_i,
  output phase_t phase_o
);

  phase_t nxt;

  always_comb begin
    nxt = phase_o;
    unique case (phase_o)
      PH_FREQ: nxt = PH_FCAP;
      PH_FCAP: nxt = fetch_halt_i ? PH_HALT : PH_EXEC;
      PH_EXEC: nxt = exec_reads_i ? PH_DCAP : PH_ICHK;
      PH_DCAP: nxt = PH_ICHK;
      PH_ICHK: nxt = PH_FREQ;
      PH_HALT: nxt = PH_HALT;
      default: nxt = PH_FREQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_o <= PH_FREQ;
    else     phase_o <= nxt;
  end

endmodule

// File: rtl/acc_cpu_irq.sv
module acc_cpu_irq #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_i,
  input  logic              chk_i,
  input  logic              reti_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] saved_o
);

  logic pend, ie;

  assign take_o = chk_i && ie && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      ie      <= 1'b1;
      saved_o <= '0;
    end else begin
      pend <= (pend && !take_o) || irq_i;
      if (take_o) begin
        saved_o <= pc_i;
        ie      <= 1'b0;
      end else if (reti_i) begin
        ie <= 1'b1;
      end
    end
  end

  assert_pend_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pend && !take_o) |=> pend);

  assert_mask_after_take_R6: assert property (@(posedge clk) disable iff (rst)
    take_o |=> (!ie && saved_o == $past(pc_i)));

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] acc_o
);

  always_ff @(posedge clk) begin
    if (rst)             acc_o <= '0;
    else if (cap_i) begin
      if (add_i)         acc_o <= acc_o + rdata_i;
      else               acc_o <= rdata_i;
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int              WORD_W       = 16,
  parameter int              ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'hF00
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              irq,
  output logic              halted
);

  localparam int OP_W = WORD_W - ADDR_W;

  phase_t            phase;
  logic [ADDR_W-1:0] pc, saved_pc, opnd;
  logic [WORD_W-1:0] ir, acc;
  logic [OP_W-1:0]   fetch_op, exec_op;
  logic              is_load, is_store, is_add, is_reti, take;

  assign fetch_op = mem_rdata[WORD_W-1:ADDR_W];
  assign exec_op  = ir[WORD_W-1:ADDR_W];
  assign opnd     = ir[ADDR_W-1:0];
  assign is_load  = exec_op == OP_W'(OPC_LOAD);
  assign is_store = exec_op == OP_W'(OPC_STORE);
  assign is_add   = exec_op == OP_W'(OPC_ADD);
  assign is_reti  = exec_op == OP_W'(OPC_RETI);

  acc_cpu_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .fetch_halt_i (fetch_op == OP_W'(OPC_HALT)),
    .exec_reads_i (is_load || is_add),
    .phase_o      (phase)
  );

  acc_cpu_irq #(.ADDR_W(ADDR_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .irq_i   (irq),
    .chk_i   (phase == PH_ICHK),
    .reti_i  (phase == PH_EXEC && is_reti),
    .pc_i    (pc),
    .take_o  (take),
    .saved_o (saved_pc)
  );

  acc_cpu_alu #(.WORD_W(WORD_W)) u_alu (
    .clk     (clk),
    .rst     (rst),
    .cap_i   (phase == PH_DCAP),
    .add_i   (is_add),
    .rdata_i (mem_rdata),
    .acc_o   (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else begin
      unique case (phase)
        PH_FCAP: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
        end
        PH_EXEC: if (is_reti) pc <= saved_pc;
        PH_ICHK: if (take) pc <= HANDLER_ADDR;
        default: ;
      endcase
    end
  end

  assign mem_rd    = (phase == PH_FREQ) || (phase == PH_EXEC && (is_load || is_add));
  assign mem_wr    = (phase == PH_EXEC) && is_store;
  assign mem_addr  = (phase == PH_FREQ) ? pc : opnd;
  assign mem_wdata = acc;
  assign halted    = (phase == PH_HALT);

  assert_rdwr_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_vector_R6: assert property (@(posedge clk) disable iff (rst)
    take |=> (mem_rd && mem_addr == HANDLER_ADDR));

endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  localparam logic [11:0] HANDLER = 12'hF00;
  localparam logic [11:0] TRIG    = 12'h900;
  localparam logic [11:0] HTRIG   = 12'h901;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        irq = 1'b0;

  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;

  logic [15:0] mem [4096];
  logic [15:0] mm  [4096];
  logic [1:0]  exp_kind [4096];
  logic [11:0] exp_addr [4096];
  logic [15:0] exp_data [4096];
  int n_exp;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  acc_cpu u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .halted(halted)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    mm[a] = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic push(input logic [1:0] k, input logic [11:0] a, input logic [15:0] d);
    exp_kind[n_exp] = k; exp_addr[n_exp] = a; exp_data[n_exp] = d;
    n_exp++;
  endtask

  // instruction-level reference: kind 0 fetch, 1 operand read, 2 write
  task automatic model_run();
    logic [11:0] pc = '0, saved = '0, a;
    logic [15:0] acc = '0, ir;
    logic [3:0]  op;
    bit ie = 1, pend = 0, stop = 0;
    int bud = 1;
    n_exp = 0;
    for (int s = 0; s < 1500 && !stop; s++) begin
      ir = mm[pc];
      push(2'd0, pc, 16'h0);
      pc = pc + 12'd1;
      op = ir[15:12];
      a  = ir[11:0];
      case (op)
        4'h0: stop = 1;
        4'h1: begin push(2'd1, a, 16'h0); acc = mm[a]; end
        4'h5: begin push(2'd1, a, 16'h0); acc = acc + mm[a]; end
        4'h2: begin
          push(2'd2, a, acc);
          mm[a] = acc;
          if (a == TRIG) pend = 1;
          else if (a == HTRIG && bud > 0) begin pend = 1; bud--; end
        end
        4'hE: begin pc = saved; ie = 1; end
        default: ;
      endcase
      if (!stop && ie && pend) begin
        saved = pc; pc = HANDLER; ie = 0; pend = 0;
      end
    end
  endtask

  task automatic load_handler();
    poke(HANDLER + 12'd0, 16'h2812);
    poke(HANDLER + 12'd1, 16'h1810);
    poke(HANDLER + 12'd2, 16'h5811);
    poke(HANDLER + 12'd3, 16'h2810);
    poke(HANDLER + 12'd4, {4'h2, HTRIG});
    poke(HANDLER + 12'd5, 16'h1812);
    poke(HANDLER + 12'd6, 16'hE000);
    poke(12'h810, 16'h0000);
    poke(12'h811, 16'h0001);
    poke(12'h812, 16'h0000);
  endtask

  task automatic run_prog();
    int idx = 0, post = 0, cyc = 0, hbud = 1;
    string tag;
    model_run();
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(mem_rd && !mem_wr && mem_addr == 12'h000 && !halted, "R11 reset fetch",
          {mem_rd, mem_wr, halted, 17'h0, mem_addr}, {3'b100, 29'h0});
    forever begin
      if (mem_rd && mem_wr) check(0, "R12 rd/wr overlap", 1, 0);
      if (mem_rd || mem_wr) begin
        if (idx >= n_exp) begin
          check(0, "R9 access beyond expected end", {20'h0, mem_addr}, 32'hFFFF_FFFF);
        end else begin
          tag = (exp_kind[idx] == 2'd0) ? "R2 R6 R8 R10 fetch" :
                (exp_kind[idx] == 2'd1) ? "R3 R5 operand read" : "R4 R7 write";
          if (exp_kind[idx] == 2'd2)
            check(mem_wr && mem_addr == exp_addr[idx] && mem_wdata == exp_data[idx], tag,
                  {mem_wr, 3'b0, mem_addr, mem_wdata}, {4'h1, exp_addr[idx], exp_data[idx]});
          else
            check(mem_rd && mem_addr == exp_addr[idx], tag,
                  {mem_rd, 19'h0, mem_addr}, {1'b1, 19'h0, exp_addr[idx]});
        end
        idx++;
      end
      if (mem_wr && mem_addr == TRIG) irq = 1'b1;
      else if (mem_wr && mem_addr == HTRIG && hbud > 0) begin irq = 1'b1; hbud--; end
      else irq = 1'b0;
      if (halted) begin
        post++;
        if (post > 12) break;
      end
      cyc++;
      if (cyc > 8000) begin
        check(0, "R9 no halt reached", 0, 1);
        break;
      end
      @(negedge clk);
      #1;
    end
    check(idx == n_exp, "R2 R9 access count", idx, n_exp);
    check(halted, "R9 halted held", halted, 1);
    for (int a = 12'h800; a <= 12'h812; a++)
      check(mem[a] === mm[a], "R3 R4 R5 data region", {a[15:0], mem[a]}, {a[15:0], mm[a]});
    rst = 1'b1;
    irq = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(150000 * 10);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin : main
    int r;
    logic [3:0] nop_op;
    r = $urandom(32'h5EED_1234);
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; mm[i] = '0; end
    repeat (3) @(negedge clk);

    // directed: wrap add, address field, unused opcode (R1 R5 R10)
    load_handler();
    poke(12'h800, 16'hFFFF);
    poke(12'h801, 16'h0002);
    poke(12'h000, 16'h1800);
    poke(12'h001, 16'h5801);
    poke(12'h002, 16'h2ABC);
    poke(12'h003, 16'h7123);
    poke(12'h004, 16'h5800);
    poke(12'h005, 16'h2802);
    poke(12'h006, 16'h0000);
    run_prog();
    check(mem[12'hABC] == 16'h0001, "R1 R5 wrapped sum at 0xABC", mem[12'hABC], 16'h0001);
    check(mem[12'h802] == 16'h0000, "R5 second wrap", mem[12'h802], 16'h0000);

    // directed: interrupt, masked request, return (R6 R7 R8)
    load_handler();
    poke(12'h803, 16'h0040);
    poke(12'h000, 16'h1803);
    poke(12'h001, {4'h2, TRIG});
    poke(12'h002, 16'h5803);
    poke(12'h003, 16'h2804);
    poke(12'h004, 16'h0000);
    run_prog();
    check(mem[12'h810] == 16'h0002, "R7 handler ran twice", mem[12'h810], 16'h0002);
    check(mem[12'h804] == 16'h0080, "R8 accumulator restored", mem[12'h804], 16'h0080);

    // constrained random programs
    for (int p = 0; p < 6; p++) begin
      load_handler();
      for (int d = 0; d < 16; d++) poke(12'h800 + d[11:0], 16'($urandom));
      for (int i = 0; i < 24; i++) begin
        r = int'($urandom % 10);
        nop_op = 4'(((int'($urandom) % 5) * 3) + 3);
        case (r)
          0, 1, 2: poke(i[11:0], {4'h1, 8'h80, 4'($urandom)});
          3, 4:    poke(i[11:0], {4'h5, 8'h80, 4'($urandom)});
          5, 6:    poke(i[11:0], {4'h2, 8'h80, 4'($urandom)});
          7:       poke(i[11:0], {4'h2, TRIG});
          default: poke(i[11:0], {nop_op, 12'($urandom)});
        endcase
      end
      poke(12'd24, 16'h0000);
      run_prog();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule